// File: doc/BRIEF.md
# Source-Routed Burst Crossbar Switch

This block is a non-blocking crossbar with a parameterized number of full-duplex ports. Each input delivers bursts of any length. Every word holds a data field, a tail flag marking the burst's final word, and a small control field. On the way in, the control field selects the output port. On the way out, the switch replaces that field with the number of the input that sent the burst, so the receiver can tell where the traffic came from.

A burst claims its output from its first word and keeps it until the tail word has been accepted downstream. When several inputs want the same output, a round-robin arbiter for that output picks one burst at a time. Unrelated input/output pairs move independently. There are no storage registers in the data path, so the valid/ready handshake runs straight through the switch: an output that is stalled holds back the input that owns it in the same cycle.

Top module: `burst_xbar`

## Requirements
- R1: A word whose control field is a legal port number P (value below the port count) appears on output P in the same cycle it is presented, with its data and tail flag unchanged. An input's ready is high only while that input is asserting valid.
- R2: On every valid output word, the control field carries the index of the input that owns the burst, zero-extended to the control width.
- R3: Once an output has been granted to an input, it stays with that input until a word with the tail flag set is accepted on that output. Until then, other inputs aiming at that output see ready low.
- R4: Each output keeps a round-robin pointer, which starts at 0. When a burst from input i completes, the pointer moves to i+1 (wrapping to 0). An idle output grants the first requesting input found searching upward from the pointer.
- R5: Bursts that go to different outputs proceed in the same cycle without affecting one another.
- R6: While an output is valid and its ready is low, the owning input's ready is low. The output keeps the same word and owner, even if other inputs begin to request that output.
- R7: A single-word burst (tail set on its first word) releases its output after one transfer, so another input can be granted in the next cycle.
- R8: A word whose control field is at or above the port count is never routed. Its input's ready stays low and no output becomes valid because of it.
- R9: After reset, no output is valid and every pointer is 0, so the first grant on each output goes to the lowest-numbered requesting input.
- R10: Bursts from one input to one output leave in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Per-input word valid |
| in_ready | output | NPORT | Per-input word accepted |
| in_data | input | NPORT*DATA_W | Per-input data, input k in bits k*DATA_W upward |
| in_tail | input | NPORT | Per-input last-word flag |
| in_ctrl | input | NPORT*CTRL_W | Per-input target port number |
| out_valid | output | NPORT | Per-output word valid |
| out_ready | input | NPORT | Per-output downstream ready |
| out_data | output | NPORT*DATA_W | Per-output data |
| out_tail | output | NPORT | Per-output last-word flag |
| out_ctrl | output | NPORT*CTRL_W | Per-output source port number |

## Verification
The hold and stability properties assume that a sender keeps a word, with the same target, on its input until that word is accepted. A burst's words are assumed to keep one target from head to tail. The bench meets this by changing an input's valid, data or control only after a transfer, or on an input that has not yet been granted. The bench drives all inputs at the falling clock edge. It checks the combinational outputs a short time later, and it counts a transfer at the rising edge only when valid and ready are both high.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_HELD = 1'b1
    } hold_e;
endpackage

// File: rtl/xbar_rr_pick.sv
module xbar_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the highest offset down so the nearest requester above base wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int pos;
            pos = (int'(base) + k) % N;
            if (req[pos]) begin
                found = 1'b1;
                idx   = IW'(pos);
            end
        end
    end
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port
    import xbar_pkg::*;
#(
    parameter int N      = 4,
    parameter int DATA_W = 36,
    parameter int CTRL_W = 4,
    parameter int IW     = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    input  logic [N*DATA_W-1:0] src_data,
    input  logic [N-1:0]      src_tail,
    input  logic              out_ready,
    output logic [N-1:0]      gnt,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_tail,
    output logic [CTRL_W-1:0] out_ctrl
);
    typedef struct packed {
        hold_e         mode;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
    } port_st_t;

    port_st_t st_q, st_d;
    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic [IW-1:0] sel;
    logic          accepted;

    xbar_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req   (req),
        .base  (st_q.ptr),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d      = st_q;
        sel       = (st_q.mode == PORT_HELD) ? st_q.owner : pick_idx;
        out_valid = ((st_q.mode == PORT_HELD) || pick_found) && req[sel];
        gnt       = '0;
        if (out_valid) gnt[sel] = 1'b1;
        out_data  = src_data[int'(sel)*DATA_W +: DATA_W];
        out_tail  = src_tail[sel];
        out_ctrl  = CTRL_W'(sel);
        accepted  = out_valid && out_ready;
        if (out_valid) begin
            if (accepted && out_tail) begin
                st_d.mode = PORT_IDLE;
                st_d.ptr  = (int'(sel) == N - 1) ? '0 : sel + 1'b1;
            end else begin
                st_d.mode  = PORT_HELD;
                st_d.owner = sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: PORT_IDLE, owner: '0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_src_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_ctrl) < N));

    assert_stall_holds_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ctrl) && $stable(out_data)));

    assert_owner_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_tail)) |=> (!out_valid || $stable(out_ctrl)));

    assert_release_after_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_tail) |=> (st_q.mode == PORT_IDLE));
endmodule

// File: rtl/burst_xbar.sv
module burst_xbar #(
    parameter int NPORT  = 4,
    parameter int DATA_W = 36,
    parameter int CTRL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        in_valid,
    output logic [NPORT-1:0]        in_ready,
    input  logic [NPORT*DATA_W-1:0] in_data,
    input  logic [NPORT-1:0]        in_tail,
    input  logic [NPORT*CTRL_W-1:0] in_ctrl,
    output logic [NPORT-1:0]        out_valid,
    input  logic [NPORT-1:0]        out_ready,
    output logic [NPORT*DATA_W-1:0] out_data,
    output logic [NPORT-1:0]        out_tail,
    output logic [NPORT*CTRL_W-1:0] out_ctrl
);
    localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic [NPORT-1:0] req_m [NPORT];
    logic [NPORT-1:0] gnt_m [NPORT];
    logic [NPORT-1:0] legal;

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            legal[i] = int'(in_ctrl[i*CTRL_W +: CTRL_W]) < NPORT;
        end
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_m[o][i] = in_valid[i] && legal[i]
                           && (in_ctrl[i*CTRL_W +: IW] == IW'(o));
            end
        end
        in_ready = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (gnt_m[o][i] && out_ready[o]) in_ready[i] = 1'b1;
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        xbar_out_port #(
            .N(NPORT), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .IW(IW)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_m[o]),
            .src_data  (in_data),
            .src_tail  (in_tail),
            .out_ready (out_ready[o]),
            .gnt       (gnt_m[o]),
            .out_valid (out_valid[o]),
            .out_data  (out_data[o*DATA_W +: DATA_W]),
            .out_tail  (out_tail[o]),
            .out_ctrl  (out_ctrl[o*CTRL_W +: CTRL_W])
        );
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_in_chk
        assert_ready_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
            in_ready[i] |-> in_valid[i]);
        assert_bad_target_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && !legal[i]) |-> !in_ready[i]);
    end
endmodule

// File: tb/sim_burst_xbar.sv
module sim_burst_xbar;
    localparam int NP = 4;
    localparam int DW = 36;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] v = '0, t = '0, ordy = '0;
    logic [CW-1:0] c [NP];
    logic [DW-1:0] d [NP];

    logic [NP-1:0]    in_valid, in_ready, in_tail, out_valid, out_tail;
    logic [NP*DW-1:0] in_data, out_data;
    logic [NP*CW-1:0] in_ctrl, out_ctrl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_data[i*DW +: DW] = d[i];
            in_ctrl[i*CW +: CW] = c[i];
        end
        in_valid = v;
        in_tail  = t;
    end

    burst_xbar #(.NPORT(NP), .DATA_W(DW), .CTRL_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_tail(in_tail), .in_ctrl(in_ctrl),
        .out_valid(out_valid), .out_ready(ordy), .out_data(out_data),
        .out_tail(out_tail), .out_ctrl(out_ctrl)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] odata(input int o);
        return out_data[o*DW +: DW];
    endfunction

    function automatic logic [CW-1:0] octrl(input int o);
        return out_ctrl[o*CW +: CW];
    endfunction

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic drive(input int i, input int tgt, input logic [DW-1:0] dat, input logic tl);
        v[i] = 1'b1; c[i] = CW'(tgt); d[i] = dat; t[i] = tl;
    endtask

    task automatic idle_all();
        @(negedge clk);
        v = '0; t = '0;
    endtask

    task automatic test_reset();
        settle();
        chk(out_valid == '0, "R9 outputs idle after reset", out_valid, 0);
        chk(in_ready == '0, "R9 no ready without valid", in_ready, 0);
    endtask

    task automatic test_single_route();
        @(negedge clk);
        ordy = '1;
        drive(0, 2, 36'h9_1234_5678, 1'b1);
        drive(1, 2, 36'h0_BEEF_0001, 1'b1);
        #2;
        chk(out_valid[2] && odata(2) == 36'h9_1234_5678, "R1 data routed to output 2", odata(2), 36'h9_1234_5678);
        chk(octrl(2) == 0, "R2 source id 0 on egress", octrl(2), 0);
        chk(out_tail[2] == 1'b1, "R1 tail passed through", out_tail[2], 1);
        chk(in_ready[0] && !in_ready[1], "R9 lowest requester granted first", in_ready, 1);
        @(negedge clk);
        v[0] = 1'b0;
        #2;
        chk(in_ready[1] && octrl(2) == 1, "R7 single word burst releases output", octrl(2), 1);
        idle_all();
    endtask

    task automatic test_hold();
        drive(1, 3, 36'h1, 1'b0);
        drive(2, 3, 36'h2, 1'b1);
        #2;
        for (int w = 0; w < 3; w++) begin
            chk(octrl(3) == 1 && odata(3) == DW'(w + 1), "R3 burst owner keeps output", octrl(3), 1);
            chk(!in_ready[2], "R3 contender stalled mid burst", in_ready[2], 0);
            @(negedge clk);
            d[1] = DW'(w + 2);
            t[1] = (w == 1);
            #2;
        end
        v[1] = 1'b0;
        #1;
        chk(octrl(3) == 2 && in_ready[2], "R3 contender granted after tail", octrl(3), 2);
        idle_all();
    endtask

    task automatic test_round_robin();
        int exp_seq [4] = '{0, 2, 3, 0};
        drive(0, 1, 36'hA0, 1'b1);
        drive(2, 1, 36'hA2, 1'b1);
        drive(3, 1, 36'hA3, 1'b1);
        #2;
        for (int k = 0; k < 4; k++) begin
            chk(out_valid[1] && octrl(1) == CW'(exp_seq[k]), "R4 round robin order", octrl(1), exp_seq[k]);
            settle();
        end
        idle_all();
    endtask

    task automatic test_backpressure();
        ordy[0] = 1'b0;
        drive(3, 0, 36'hC3, 1'b0);
        #2;
        chk(out_valid[0] && !in_ready[3], "R6 stalled output holds off owner", in_ready[3], 0);
        @(negedge clk);
        drive(1, 0, 36'hC1, 1'b1);
        #2;
        chk(octrl(0) == 3 && odata(0) == 36'hC3, "R6 word and owner held under stall", octrl(0), 3);
        chk(!in_ready[1], "R6 newcomer cannot steal stalled output", in_ready[1], 0);
        @(negedge clk);
        ordy[0] = 1'b1;
        t[3] = 1'b1;
        #2;
        chk(in_ready[3] && out_tail[0], "R6 transfer resumes when ready returns", in_ready[3], 1);
        @(negedge clk);
        v[3] = 1'b0;
        #2;
        chk(octrl(0) == 1 && in_ready[1], "R3 next owner after release", octrl(0), 1);
        idle_all();
    endtask

    task automatic test_parallel();
        drive(0, 3, 36'h30, 1'b1);
        drive(1, 2, 36'h21, 1'b1);
        #2;
        chk(in_ready[0] && in_ready[1], "R5 disjoint pairs both ready", in_ready, 3);
        chk(odata(3) == 36'h30 && odata(2) == 36'h21 && octrl(3) == 0 && octrl(2) == 1,
            "R5 disjoint outputs carry own words", odata(3), 36'h30);
        idle_all();
    endtask

    task automatic test_bad_target();
        drive(2, 7, 36'hBAD, 1'b1);
        #2;
        chk(!in_ready[2], "R8 illegal target stalled", in_ready[2], 0);
        chk(out_valid == '0, "R8 illegal target not routed", out_valid, 0);
        idle_all();
    endtask

    task automatic test_order();
        drive(0, 1, 36'h111, 1'b1);
        #2;
        chk(odata(1) == 36'h111, "R10 first burst leaves first", odata(1), 36'h111);
        @(negedge clk);
        d[0] = 36'h222;
        #2;
        chk(odata(1) == 36'h222, "R10 second burst follows", odata(1), 36'h222);
        idle_all();
    endtask

    initial begin
        for (int i = 0; i < NP; i++) begin
            c[i] = '0;
            d[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_single_route();
        test_hold();
        test_round_robin();
        test_backpressure();
        test_parallel();
        test_bad_target();
        test_order();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule